// File: doc/BRIEF.md
# MII Receive Frame Checker

This block watches the 4-bit receive side of a media-independent interface: a data nibble, a data-valid strobe and an error strobe. For each frame it tracks the preamble up to the start-of-frame nibble and counts the data nibbles that follow. It also notes any error-strobe activity. When data-valid falls, it issues a one-cycle report. The report holds a 16-bit status word and a drop flag that downstream receive logic uses to discard the frame.

Two control inputs select optional preamble rules. One rejects a preamble that contains any nibble other than 0x5. The other rejects a preamble longer than a set number of bytes. The checker does not inspect CRC, addresses or payload content. It only sees the nibble stream.

Top module: `mii_rx_frame_checker`

## Requirements
- R1: After reset, `stat_valid` and `stat_drop` are 0 and `stat_word` is 0x0000.
- R2: A frame is the run of cycles with `mii_rxdv`=1. In the cycle after the first cycle that samples `mii_rxdv`=0, `stat_valid` is 1 for exactly one cycle. `stat_word` and `stat_drop` are valid in that cycle.
- R3: The preamble is every nibble of a frame before the first 0xD nibble. With `pure_pre_en`=1, a preamble nibble other than 0x5 sets status bit 12. With `pure_pre_en`=0, such a nibble has no effect on the status.
- R4: With `long_pre_rej_en`=1, a preamble of more than 2*MAX_PRE_BYTES nibbles (default 22) sets bit 12. Exactly 22 nibbles does not set it. With `long_pre_rej_en`=0, preamble length has no effect.
- R5: More than LONG_EVENT_NIB data nibbles after the 0xD nibble (default 12500, which is 50,000 bit times) sets bit 12.
- R6: An odd count of data nibbles sets bit 14.
- R7: Fewer than MIN_FRAME_NIB data nibbles (default 128) sets bit 1. A frame with no 0xD nibble counts as zero data nibbles.
- R8: `mii_rxer`=1 in any cycle of a frame sets bit 3.
- R9: A cycle with `mii_rxer`=1, `mii_rxdv`=0 and `mii_rxd`=0xE between frames sets bit 2 in the report of the next frame only.
- R10: Bit 15 is 1 exactly when bits 1, 3, 12 and 14 are all 0. `stat_drop` equals bit 1 OR bit 12. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| mii_rxd | input | 4 | Receive data nibble, low nibble of each byte first |
| mii_rxdv | input | 1 | Receive data valid |
| mii_rxer | input | 1 | Receive error |
| pure_pre_en | input | 1 | Enable preamble purity rejection |
| long_pre_rej_en | input | 1 | Enable long preamble rejection |
| stat_valid | output | 1 | One-cycle end-of-frame report strobe |
| stat_word | output | 16 | Frame status word |
| stat_drop | output | 1 | Frame should be discarded |

## Verification
Every result appears in a single register stage behind the end of the frame. The bench drives `mii_rxdv` low on a falling edge. The next rising edge captures the report, so the bench samples `stat_word`, `stat_drop` and `stat_valid` on the falling edge that follows. It samples one falling edge later to confirm that the strobe has cleared. A carrier event is injected as one idle cycle before a frame, and its effect is checked on that frame's report and on the report of the frame after it. Length limits are tested on both sides of each threshold.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2
    } rx_phase_t;

    localparam logic [3:0] NIB_PRE  = 4'h5;
    localparam logic [3:0] NIB_SFD  = 4'hD;
    localparam logic [3:0] NIB_CARR = 4'hE;

    localparam int BIT_SHORT  = 1;
    localparam int BIT_CARR   = 2;
    localparam int BIT_CODEV  = 3;
    localparam int BIT_DROPEV = 12;
    localparam int BIT_ALIGN  = 14;
    localparam int BIT_OK     = 15;

    typedef struct packed {
        logic align;
        logic dropev;
        logic codev;
        logic carrier;
        logic runt;
    } rx_flags_t;

    function automatic logic flags_clean(rx_flags_t f);
        return !(f.runt | f.codev | f.dropev | f.align);
    endfunction

    function automatic logic [15:0] pack_status(rx_flags_t f);
        logic [15:0] w;
        w             = '0;
        w[BIT_SHORT]  = f.runt;
        w[BIT_CARR]   = f.carrier;
        w[BIT_CODEV]  = f.codev;
        w[BIT_DROPEV] = f.dropev;
        w[BIT_ALIGN]  = f.align;
        w[BIT_OK]     = flags_clean(f);
        return w;
    endfunction

endpackage

// File: rtl/rxchk_preamble.sv
module rxchk_preamble
    import rxchk_pkg::*;
#(
    parameter int MAX_PRE_BYTES = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       first,
    input  logic       in_pre,
    input  logic [3:0] rxd,
    output logic       impure,
    output logic       long_pre
);
    localparam int LIMIT = 2 * MAX_PRE_BYTES;
    localparam int CAP   = LIMIT + 1;
    localparam int CW    = $clog2(CAP + 1);

    logic [CW-1:0] pre_cnt;
    logic          imp_q;
    logic          is_sfd;
    logic          bad_nib;

    assign is_sfd  = (rxd == NIB_SFD);
    assign bad_nib = !is_sfd && (rxd != NIB_PRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            imp_q   <= 1'b0;
        end else if (first) begin
            pre_cnt <= is_sfd ? CW'(0) : CW'(1);
            imp_q   <= bad_nib;
        end else if (in_pre && !is_sfd) begin
            if (pre_cnt != CW'(CAP))
                pre_cnt <= pre_cnt + 1'b1;
            imp_q <= imp_q | bad_nib;
        end
    end

    assign impure   = imp_q;
    assign long_pre = (pre_cnt > CW'(LIMIT));

    // R3/R4: preamble record is frozen outside the preamble phase
    a_r3_pre_hold: assert property (@(posedge clk) disable iff (rst)
        (!first && !in_pre) |=> ($stable(pre_cnt) && $stable(imp_q)));

    a_r4_pre_cap: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= CW'(CAP));

endmodule

// File: rtl/rxchk_length.sv
module rxchk_length #(
    parameter int MIN_NIB  = 128,
    parameter int LONG_NIB = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic runt,
    output logic odd,
    output logic over
);
    localparam int CAP = LONG_NIB + 1;
    localparam int CW  = $clog2(CAP + 1);

    logic [CW-1:0] nib_cnt;
    logic          par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_cnt <= '0;
            par_q   <= 1'b0;
        end else if (clr) begin
            nib_cnt <= '0;
            par_q   <= 1'b0;
        end else if (inc) begin
            if (nib_cnt != CW'(CAP))
                nib_cnt <= nib_cnt + 1'b1;
            par_q <= ~par_q;
        end
    end

    assign runt = (nib_cnt < CW'(MIN_NIB));
    assign odd  = par_q;
    assign over = (nib_cnt > CW'(LONG_NIB));

    // R5: saturating counter never passes its cap
    a_r5_cnt_cap: assert property (@(posedge clk) disable iff (rst)
        nib_cnt <= CW'(CAP));

    // R6: every counted nibble flips parity
    a_r6_parity_flip: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (par_q != $past(par_q)));

endmodule

// File: rtl/mii_rx_frame_checker.sv
module mii_rx_frame_checker
    import rxchk_pkg::*;
#(
    parameter int MAX_PRE_BYTES  = 11,
    parameter int MIN_FRAME_NIB  = 128,
    parameter int LONG_EVENT_NIB = 12500
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  mii_rxd,
    input  logic        mii_rxdv,
    input  logic        mii_rxer,
    input  logic        pure_pre_en,
    input  logic        long_pre_rej_en,
    output logic        stat_valid,
    output logic [15:0] stat_word,
    output logic        stat_drop
);
    rx_phase_t phase_q, phase_d;
    logic      first, in_pre, in_data, eof;
    logic      codev_q, carr_q, carr_now;
    logic      impure, long_pre, runt, odd, over;
    rx_flags_t flags;

    assign first    = mii_rxdv && (phase_q == PH_IDLE);
    assign in_pre   = mii_rxdv && (phase_q == PH_PRE);
    assign in_data  = mii_rxdv && (phase_q == PH_DATA);
    assign eof      = !mii_rxdv && (phase_q != PH_IDLE);
    assign carr_now = !mii_rxdv && mii_rxer && (mii_rxd == NIB_CARR);

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (mii_rxdv) phase_d = (mii_rxd == NIB_SFD) ? PH_DATA : PH_PRE;
            PH_PRE:  if (!mii_rxdv) phase_d = PH_IDLE;
                     else if (mii_rxd == NIB_SFD) phase_d = PH_DATA;
            PH_DATA: if (!mii_rxdv) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    rxchk_preamble #(.MAX_PRE_BYTES(MAX_PRE_BYTES)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .first    (first),
        .in_pre   (in_pre),
        .rxd      (mii_rxd),
        .impure   (impure),
        .long_pre (long_pre)
    );

    rxchk_length #(.MIN_NIB(MIN_FRAME_NIB), .LONG_NIB(LONG_EVENT_NIB)) u_len (
        .clk  (clk),
        .rst  (rst),
        .clr  (first),
        .inc  (in_data),
        .runt (runt),
        .odd  (odd),
        .over (over)
    );

    always_comb begin
        flags.runt    = runt;
        flags.carrier = carr_q;
        flags.codev   = codev_q;
        flags.align   = odd;
        flags.dropev  = over || (pure_pre_en && impure) || (long_pre_rej_en && long_pre);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            codev_q    <= 1'b0;
            carr_q     <= 1'b0;
            stat_valid <= 1'b0;
            stat_word  <= '0;
            stat_drop  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (first)
                codev_q <= mii_rxer;
            else if (mii_rxdv)
                codev_q <= codev_q | mii_rxer;
            if (eof) begin
                carr_q     <= carr_now;
                stat_valid <= 1'b1;
                stat_word  <= pack_status(flags);
                stat_drop  <= flags.runt | flags.dropev;
            end else begin
                if (carr_now)
                    carr_q <= 1'b1;
                stat_valid <= 1'b0;
            end
        end
    end

    // R2: report strobe lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        stat_valid |=> !stat_valid);

    // R2: a report follows only the end of a frame
    a_r2_after_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_valid) |-> ($past(phase_q) != PH_IDLE && !$past(mii_rxdv)));

    // R10: intact bit excludes every error bit
    a_r10_ok_exclusive: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !(stat_word[BIT_OK] &&
            (stat_word[BIT_SHORT] | stat_word[BIT_CODEV] |
             stat_word[BIT_DROPEV] | stat_word[BIT_ALIGN])));

    // R10: a dropped frame is never reported intact
    a_r10_drop_not_ok: assert property (@(posedge clk) disable iff (rst)
        stat_drop && stat_valid |-> !stat_word[BIT_OK]);

endmodule

// File: tb/mii_rx_frame_checker_test.sv
module mii_rx_frame_checker_test;
    localparam int MIN_NIB  = 128;
    localparam int LONG_NIB = 12500;
    localparam int PRE_LIM  = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mii_rxd = 4'h0;
    logic        mii_rxdv = 1'b0;
    logic        mii_rxer = 1'b0;
    logic        pure_pre_en = 1'b0;
    logic        long_pre_rej_en = 1'b0;
    logic        stat_valid;
    logic [15:0] stat_word;
    logic        stat_drop;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mii_rx_frame_checker uut (
        .clk             (clk),
        .rst             (rst),
        .mii_rxd         (mii_rxd),
        .mii_rxdv        (mii_rxdv),
        .mii_rxer        (mii_rxer),
        .pure_pre_en     (pure_pre_en),
        .long_pre_rej_en (long_pre_rej_en),
        .stat_valid      (stat_valid),
        .stat_word       (stat_word),
        .stat_drop       (stat_drop)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // npre preamble nibbles, badpos = index of a 0x3 nibble (-1 none),
    // ndata data nibbles after 0xD (-1 = no 0xD at all), erpos = data index with rxer
    task automatic run_frame(string req, int npre, int badpos, int ndata, int erpos,
                             bit carr_before, bit exp_carr);
        logic [15:0] w;
        bit sh, al, cv, de, ok;
        if (carr_before) begin
            @(negedge clk);
            mii_rxer = 1'b1; mii_rxd = 4'hE;
            @(negedge clk);
            mii_rxer = 1'b0; mii_rxd = 4'h0;
        end
        for (int i = 0; i < npre; i++) begin
            @(negedge clk);
            mii_rxdv = 1'b1; mii_rxer = 1'b0;
            mii_rxd  = (i == badpos) ? 4'h3 : 4'h5;
        end
        if (ndata >= 0) begin
            @(negedge clk);
            mii_rxdv = 1'b1; mii_rxd = 4'hD; mii_rxer = 1'b0;
            for (int i = 0; i < ndata; i++) begin
                @(negedge clk);
                mii_rxd  = 4'(i);
                mii_rxer = (i == erpos);
            end
        end
        @(negedge clk);
        mii_rxdv = 1'b0; mii_rxer = 1'b0; mii_rxd = 4'h0;
        sh = (ndata < MIN_NIB);
        al = (ndata > 0) && (ndata % 2 == 1);
        cv = (erpos >= 0);
        de = (pure_pre_en && badpos >= 0) || (long_pre_rej_en && npre > PRE_LIM) ||
             (ndata > LONG_NIB);
        ok = !(sh | al | cv | de);
        w = '0;
        w[1] = sh; w[2] = exp_carr; w[3] = cv; w[12] = de; w[14] = al; w[15] = ok;
        @(negedge clk);
        chk({req, " R2 strobe"}, 32'(stat_valid), 32'd1);
        chk({req, " word"}, 32'(stat_word), 32'(w));
        chk({req, " R10 drop"}, 32'(stat_drop), 32'(sh | de));
        @(negedge clk);
        chk({req, " R2 strobe ends"}, 32'(stat_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 valid", 32'(stat_valid), 32'd0);
        chk("R1 word", 32'(stat_word), 32'd0);
        chk("R1 drop", 32'(stat_drop), 32'd0);
    endtask

    task automatic t_basic;
        run_frame("R10 intact", 15, -1, 128, -1, 0, 0);
        run_frame("R6 odd", 15, -1, 129, -1, 0, 0);
        run_frame("R7 runt", 15, -1, 20, -1, 0, 0);
        run_frame("R7 no sfd", 10, -1, -1, -1, 0, 0);
        run_frame("R8 rxer", 15, -1, 130, 40, 0, 0);
    endtask

    task automatic t_purity;
        pure_pre_en = 1'b1;
        run_frame("R3 impure on", 15, 6, 128, -1, 0, 0);
        run_frame("R3 pure on", 15, -1, 128, -1, 0, 0);
        pure_pre_en = 1'b0;
        run_frame("R3 impure off", 15, 6, 128, -1, 0, 0);
    endtask

    task automatic t_long_pre;
        long_pre_rej_en = 1'b1;
        run_frame("R4 23 nib", 23, -1, 128, -1, 0, 0);
        run_frame("R4 22 nib", 22, -1, 128, -1, 0, 0);
        long_pre_rej_en = 1'b0;
        run_frame("R4 off", 30, -1, 128, -1, 0, 0);
    endtask

    task automatic t_carrier;
        run_frame("R9 carrier", 15, -1, 128, -1, 1, 1);
        run_frame("R9 cleared", 15, -1, 128, -1, 0, 0);
    endtask

    task automatic t_long_event;
        run_frame("R5 at limit", 15, -1, LONG_NIB, -1, 0, 0);
        run_frame("R5 over", 15, -1, LONG_NIB + 2, -1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_purity();
        t_long_pre();
        t_carrier();
        t_long_event();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule